// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

The block collects hardware event pulses into a bank of sticky status bits and drives one level-sensitive interrupt line. The line is high when at least one status bit is set and not masked. Software sees four 32-bit word registers through a plain write/read port. Status bits are cleared by writing ones to them. The mask cannot be loaded directly. It changes only through two command words: one clears mask bits and so lets those sources through, the other sets mask bits and so blocks them. After reset every source is masked. The width `NBITS` is a parameter, so a two-source group and a one-source group are two instances of the same block.

Register word index (`bus_addr`): 0 = status (read; write-one-to-clear), 1 = mask (read only), 2 = unmask command (write only), 3 = mask command (write only). Reads are combinational from `bus_addr`, and the data is zero-extended to 32 bits. The interrupt output is registered. It follows the status and mask registers one clock later.

The design holds no state machine. Its only states are the status and mask registers and the interrupt flop. The transitions are event set, software clear, unmask, mask and reset, and the requirements list them.

Top module: `intr_mask_unit`

## Requirements
- R1: After reset, status reads 0, mask reads all ones (3 for NBITS=2) and `irq_o` is low.
- R2: A 1 on `evt_set[i]` at a clock edge sets status bit i, and the bit stays set until software clears it.
- R3: A write to word 0 clears the status bits where the write data (bits NBITS-1:0) holds ones. Bits where the data holds zeros are left unchanged.
- R4: If `evt_set[i]` and a write-one-to-clear of bit i occur at the same edge, bit i ends set.
- R5: A write to word 2 clears the mask bits where the data holds ones. Other mask bits are unchanged.
- R6: A write to word 3 sets the mask bits where the data holds ones. Other mask bits are unchanged.
- R7: Words 2 and 3 read as 0, and a write to word 1 leaves the mask unchanged.
- R8: `irq_o` equals the OR of (status AND NOT mask) as it stood before the previous clock edge, a delay of one cycle.
- R9: Write data bits at NBITS and above have no effect, and read data bits at NBITS and above are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_set | input | NBITS | Per-bit event set inputs |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `bus_wr`, `bus_addr`, `bus_wdata` and `evt_set` are synchronous to `clk`, hold known values at every edge, and stay low during reset. The assertions on the command registers also assume that one write addresses one word. The bench changes every input on the falling edge, holds events low during reset, and issues at most one write per cycle. It sweeps every start status, every start mask, every data value and every coincident event pattern on the two-bit instance, with junk in the upper data bits.

// File: rtl/imu_pkg.sv
package imu_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RG_STATUS  = 2'd0,
        RG_MASK    = 2'd1,
        RG_UNMASK  = 2'd2,
        RG_MASKSET = 2'd3
    } reg_e;
endpackage

// File: rtl/imu_decode.sv
module imu_decode
    import imu_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              clr_stb,
    output logic              unmask_stb,
    output logic              maskset_stb,
    output reg_e              rd_sel
);
    always_comb begin
        clr_stb     = 1'b0;
        unmask_stb  = 1'b0;
        maskset_stb = 1'b0;
        rd_sel      = reg_e'(addr);
        unique case (rd_sel)
            RG_STATUS:  clr_stb     = wr;
            RG_MASK:    ;
            RG_UNMASK:  unmask_stb  = wr;
            RG_MASKSET: maskset_stb = wr;
            default:    ;
        endcase
    end
endmodule

// File: rtl/imu_status.sv
module imu_status #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_stb,
    input  logic [NBITS-1:0] clr_bits,
    input  logic [NBITS-1:0] evt_set,
    output logic [NBITS-1:0] status_q
);
    logic [NBITS-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_stb ? clr_bits : '0;
    end

    // event set applied after clear: set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | evt_set;
    end
endmodule

// File: rtl/imu_mask.sv
module imu_mask #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unmask_stb,
    input  logic             maskset_stb,
    input  logic [NBITS-1:0] cmd_bits,
    output logic [NBITS-1:0] mask_q
);
    logic [NBITS-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (unmask_stb)  mask_d = mask_d & ~cmd_bits;
        if (maskset_stb) mask_d = mask_d | cmd_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/intr_mask_unit.sv
module intr_mask_unit
    import imu_pkg::*;
#(
    parameter int NBITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NBITS-1:0]  evt_set,
    output logic              irq_o
);
    logic             clr_stb, unmask_stb, maskset_stb;
    reg_e             rd_sel;
    logic [NBITS-1:0] wbits;
    logic [NBITS-1:0] status_q;
    logic [NBITS-1:0] mask_q;
    logic             pend;

    assign wbits = bus_wdata[NBITS-1:0];

    imu_decode u_dec (
        .wr          (bus_wr),
        .addr        (bus_addr),
        .clr_stb     (clr_stb),
        .unmask_stb  (unmask_stb),
        .maskset_stb (maskset_stb),
        .rd_sel      (rd_sel)
    );

    imu_status #(.NBITS(NBITS)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_stb  (clr_stb),
        .clr_bits (wbits),
        .evt_set  (evt_set),
        .status_q (status_q)
    );

    imu_mask #(.NBITS(NBITS)) u_mk (
        .clk         (clk),
        .rst_n       (rst_n),
        .unmask_stb  (unmask_stb),
        .maskset_stb (maskset_stb),
        .cmd_bits    (wbits),
        .mask_q      (mask_q)
    );

    assign pend = |(status_q & ~mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pend;
    end

    always_comb begin
        unique case (rd_sel)
            RG_STATUS: bus_rdata = DATA_W'(status_q);
            RG_MASK:   bus_rdata = DATA_W'(mask_q);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/imu_checker.sv
module imu_checker #(
    parameter int NBITS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NBITS-1:0] evt_set,
    input logic [NBITS-1:0] st,
    input logic [NBITS-1:0] mk,
    input logic             irq_o
);
    logic [NBITS-1:0] wb;
    assign wb = bus_wdata[NBITS-1:0];

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st & ~mk)) |=> irq_o); // R8
    AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st & ~mk)) |=> !irq_o); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && evt_set == '0) |=> ((st & $past(wb)) == '0)); // R3
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((st & $past(evt_set)) == $past(evt_set))); // R4
    AST_UNMASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> ((mk & $past(wb)) == '0)); // R5
    AST_MASKSET_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ((mk & $past(wb)) == $past(wb))); // R6
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[1]) |=> $stable(mk)); // R7
    AST_CMD_RDZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[1] |-> (bus_rdata == 32'd0)); // R7
endmodule

bind intr_mask_unit imu_checker #(.NBITS(NBITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_set   (evt_set),
    .st        (status_q),
    .mk        (mask_q),
    .irq_o     (irq_o)
);

// File: tb/intr_mask_unit_test.sv
module intr_mask_unit_test;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [31:0]   bus_wdata = 32'd0;
    logic [31:0]   bus_rdata;
    logic [NB-1:0] evt_set = '0;
    logic          irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [NB-1:0] m_st, m_mk;

    intr_mask_unit #(.NBITS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
        .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, then model update and two irq checks
    task automatic op(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic [NB-1:0] e);
        logic old_p, new_p;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_set = e;
        old_p = |(m_st & ~m_mk);
        @(posedge clk);
        if (wr && a == 2'd0) m_st = m_st & ~d[NB-1:0];
        m_st = m_st | e;
        if (wr && a == 2'd2) m_mk = m_mk & ~d[NB-1:0];
        if (wr && a == 2'd3) m_mk = m_mk | d[NB-1:0];
        new_p = |(m_st & ~m_mk);
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0;
        chk("R8 irq lag", 32'(irq_o), 32'(old_p));
        @(negedge clk);
        chk("R8 irq follow", 32'(irq_o), 32'(new_p));
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_wr = 1'b0; evt_set = '0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic setup(input logic [NB-1:0] s, input logic [NB-1:0] m);
        op(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
        op(1'b1, 2'd3, 32'h0000_0003, '0);
        op(1'b1, 2'd2, 32'(~m & 2'b11), '0);
        op(1'b0, 2'd0, 32'd0, s);
    endtask

    initial begin
        m_st = '0; m_mk = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 status", 2'd0, 32'd0);
        rd("R1 mask", 2'd1, 32'd3);
        chk("R1 irq", 32'(irq_o), 32'd0);
        rd("R7 unmask reads 0", 2'd2, 32'd0);
        rd("R7 maskset reads 0", 2'd3, 32'd0);

        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                setup(NB'(s), NB'(m));
                rd("R2 status set", 2'd0, 32'(s));
                rd("R6 mask built", 2'd1, 32'(m));
                for (int w = 0; w < 4; w++) begin
                    for (int e = 0; e < 4; e++) begin
                        setup(NB'(s), NB'(m));
                        op(1'b1, 2'd0, 32'hFFFF_FFF0 | 32'(w), NB'(e));
                        if ((w & e) != 0)
                            rd("R4 set wins", 2'd0, 32'((s & ~w | e) & 3));
                        else
                            rd("R3 w1c", 2'd0, 32'((s & ~w | e) & 3));
                    end
                    setup(NB'(s), NB'(m));
                    op(1'b1, 2'd2, 32'hABCD_0000 | 32'(w), '0);
                    rd("R5 unmask", 2'd1, 32'(m & ~w & 3));
                    setup(NB'(s), NB'(m));
                    op(1'b1, 2'd3, 32'(w), '0);
                    rd("R6 maskset", 2'd1, 32'((m | w) & 3));
                    setup(NB'(s), NB'(m));
                    op(1'b1, 2'd1, 32'(w), '0);
                    rd("R7 mask not writable", 2'd1, 32'(m));
                    rd("R7 unmask reads 0", 2'd2, 32'd0);
                    rd("R7 maskset reads 0", 2'd3, 32'd0);
                end
            end
        end

        // R9 upper data bits ignored, reads zero-extended
        setup(2'b00, 2'b00);
        op(1'b1, 2'd3, 32'hFFFF_FFFC, '0);
        rd("R9 upper bits ignored", 2'd1, 32'd0);
        op(1'b1, 2'd0, 32'hFFFF_FFFC, 2'b11);
        op(1'b1, 2'd0, 32'hFFFF_FFFC, '0);
        rd("R9 status zero-extended", 2'd0, 32'd3);
        chk("R9 irq with unmasked status", 32'(irq_o), 32'd1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule